// File: doc/BRIEF.md
# Sound Envelope Generator

This block produces the 5-bit amplitude envelope that a three-voice sound generator applies to any channel set to variable level. A 16-bit period value sets how fast the envelope steps. A 4-bit shape code sets the form of the envelope: a ramp up or a ramp down, a single ramp that drops to zero, a repeating sawtooth, a triangle that reverses direction on every cycle, or a ramp that stops at its end value.

A pulse on the shape-write strobe captures the shape code and starts the pattern again from its first step. The step timer is cleared at the same time. Steps are counted only in clocks where the master-clock enable is high, so a system clock that runs faster than the sound master clock works through this enable. The block has no data stream. Every pin is a plain control or status pin, and no handshake is involved. The period input is sampled live, while the shape code counts only at a write.

Top module: `env_gen`

## Requirements
- R1: After reset the level output is 0. It stays 0, whatever tick_en, period and shape do, until the first cycle in which shape_wr is high.
- R2: The envelope advances by one step on the 8·EP-th enabled tick after a restart or after the previous step. EP is the period input, and EP = 0 is treated as 1. Clocks in which tick_en is low do not count.
- R3: A pattern cycle has 32 steps. With the ATT bit at 1 the first cycle reads 0, 1, … 31. With the ATT bit at 0 it reads 31, 30, … 0.
- R4: With the CONT bit at 0, the level becomes 0 at the step after the first cycle ends and stays 0 until the next write. ALT and HOLD have no effect in this case.
- R5: With CONT = 1, ALT = 0 and HOLD = 0, each new cycle repeats the first cycle's ramp in the same direction, with no end.
- R6: With CONT = 1, ALT = 1 and HOLD = 0, each new cycle runs in the opposite direction to the previous one, which gives a triangle.
- R7: With CONT = 1 and HOLD = 1, the level freezes after the first cycle. The frozen value is 31 when ATT xor ALT is 1, and 0 otherwise.
- R8: A cycle with shape_wr high restarts the pattern and clears the step timer. In the following cycle the level equals the first value of the new shape: 0 if ATT = 1, 31 if ATT = 0.
- R9: The shape code bits are [3] = CONT, [2] = ATT, [1] = ALT and [0] = HOLD. They are captured only when shape_wr is high. A change of the shape input without a write has no effect on the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Master-clock enable; one tick per high cycle |
| period | input | 16 | Envelope period EP |
| shape | input | 4 | Shape code {CONT, ATT, ALT, HOLD} |
| shape_wr | input | 1 | Shape write strobe; captures the shape and restarts the pattern |
| level | output | 5 | Envelope level |

## Verification
The hardest cases to reach are the ends of a pattern cycle. These are the step where 31 rolls over into a hold, a reversal or a repeat, and a restart that arrives partway through a ramp. Reaching them by the natural route would take tens of thousands of ticks. The stimulus therefore uses the shortest period, so one cycle takes 256 enabled ticks, and walks all sixteen shape codes through three full cycles each. It then writes a new shape in the middle of a ramp, and it gates tick_en irregularly so that step timing is checked when the enable is not high in every clock.

// File: rtl/env_pkg.sv
package env_pkg;
  typedef struct packed {
    logic cont;
    logic att;
    logic alt;
    logic hold;
  } env_shape_t;
endpackage

// File: rtl/env_prescaler.sv
module env_prescaler #(
  parameter int PERIOD_W   = 16,
  parameter int SCALE_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                run,
  input  logic                tick_en,
  input  logic [PERIOD_W-1:0] period,
  output logic                step_pulse
);
  localparam int CW = PERIOD_W + SCALE_LOG2;

  logic [CW-1:0]       cnt;
  logic [CW-1:0]       limit;
  logic [PERIOD_W-1:0] ep_eff;

  always_comb begin
    ep_eff = (period == '0) ? PERIOD_W'(1) : period;
    limit  = {ep_eff, {SCALE_LOG2{1'b0}}} - CW'(1);
  end

  assign step_pulse = run && tick_en && !restart && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt <= '0;
    end else if (run && tick_en) begin
      if (cnt >= limit) cnt <= '0;
      else              cnt <= cnt + CW'(1);
    end
  end

  // R2: a count never advances in a clock without a tick
  a_r2_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !restart) |=> $stable(cnt));
endmodule

// File: rtl/env_shaper.sv
module env_shaper
  import env_pkg::*;
#(
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  env_shape_t        shape_in,
  input  logic              step_pulse,
  output logic              active,
  output logic [STEP_W-1:0] level
);
  localparam logic [STEP_W-1:0] TOP = {STEP_W{1'b1}};

  env_shape_t        shp;
  logic              holding;
  logic              dir_up;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] held;
  logic [STEP_W-1:0] ramp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      holding <= 1'b0;
      shp     <= '0;
      dir_up  <= 1'b0;
      step    <= '0;
      held    <= '0;
    end else if (restart) begin
      active  <= 1'b1;
      holding <= 1'b0;
      shp     <= shape_in;
      dir_up  <= shape_in.att;
      step    <= '0;
      held    <= '0;
    end else if (active && !holding && step_pulse) begin
      if (step == TOP) begin
        if (!shp.cont) begin
          holding <= 1'b1;
          held    <= '0;
        end else if (shp.hold) begin
          holding <= 1'b1;
          held    <= (dir_up ^ shp.alt) ? TOP : '0;
        end else begin
          step <= '0;
          if (shp.alt) dir_up <= !dir_up;
        end
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end

  always_comb begin
    ramp = dir_up ? step : ~step;
    if (!active)      level = '0;
    else if (holding) level = held;
    else              level = ramp;
  end

  // R2: the step only moves on a timer pulse or a restart
  a_r2_step_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_pulse && !restart) |=> $stable(step));
  // R3: inside a cycle each pulse moves exactly one step
  a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !holding && step_pulse && !restart && step != TOP) |=> step == $past(step) + STEP_W'(1));
  // R4: a one-shot shape rests at zero
  a_r4_oneshot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !shp.cont) |-> level == '0);
  // R7: a held level does not move until the next write
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !restart) |=> $stable(level));
endmodule

// File: rtl/env_gen.sv
module env_gen
  import env_pkg::*;
#(
  parameter int PERIOD_W   = 16,
  parameter int STEP_W     = 5,
  parameter int SCALE_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic [PERIOD_W-1:0] period,
  input  logic [3:0]          shape,
  input  logic                shape_wr,
  output logic [STEP_W-1:0]   level
);
  logic       step_pulse;
  logic       active;
  env_shape_t shape_s;

  assign shape_s = env_shape_t'(shape);

  env_prescaler #(.PERIOD_W(PERIOD_W), .SCALE_LOG2(SCALE_LOG2)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (shape_wr),
    .run        (active),
    .tick_en    (tick_en),
    .period     (period),
    .step_pulse (step_pulse)
  );

  env_shaper #(.STEP_W(STEP_W)) u_shp (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (shape_wr),
    .shape_in   (shape_s),
    .step_pulse (step_pulse),
    .active     (active),
    .level      (level)
  );

  // R8: the cycle after a write shows the first value of the new shape
  a_r8_restart_start: assert property (@(posedge clk) disable iff (!rst_n)
    shape_wr |=> level == ($past(shape[2]) ? '0 : {STEP_W{1'b1}}));
  // R1: before any write the output is silent
  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> level == '0);
endmodule

// File: tb/env_gen_tb.sv
`timescale 1ns/1ps
module env_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [15:0] period = 16'd1;
  logic [3:0]  shape = 4'd0;
  logic        shape_wr = 1'b0;
  logic [4:0]  level;

  always #4 clk = ~clk;

  env_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period(period),
    .shape(shape), .shape_wr(shape_wr), .level(level)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // reference model: elapsed ticks, position in cycle, cycle index
  bit       m_run = 0;
  bit [3:0] m_shape = 0;
  int       m_ticks = 0;
  int       m_pos = 0;
  int       m_cyc = 0;

  function automatic bit m_frozen();
    return (m_cyc >= 1) && (!m_shape[3] || m_shape[0]);
  endfunction

  function automatic int m_level();
    bit up;
    if (!m_run) return 0;
    if (m_frozen()) begin
      if (!m_shape[3]) return 0;
      return (m_shape[2] ^ m_shape[1]) ? 31 : 0;
    end
    up = m_shape[2] ^ (m_shape[1] & m_cyc[0]);
    return up ? m_pos : 31 - m_pos;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_ticks = 0; m_pos = 0; m_cyc = 0;
    end else if (shape_wr) begin
      m_run = 1; m_shape = shape; m_ticks = 0; m_pos = 0; m_cyc = 0;
    end else if (m_run && tick_en) begin
      m_ticks++;
      if (m_ticks >= 8 * ((period == 0) ? 1 : int'(period))) begin
        m_ticks = 0;
        if (!m_frozen()) begin
          m_pos++;
          if (m_pos == 32) begin m_pos = 0; m_cyc++; end
        end
      end
    end
  end

  task automatic check(input int act, input int exp, input string req);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: level=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (cmp_on && rst_n) check(int'(level), m_level(), cur_req);
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_shape(input bit [3:0] s);
    @(negedge clk);
    shape = s; shape_wr = 1'b1;
    @(negedge clk);
    shape_wr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: level=%0d expected=finish", level);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(level), 0, "R1 reset");
    cmp_on = 1'b1;
    tick_en = 1'b1;
    cur_req = "R1";
    period = 16'd0;
    shape = 4'hF;
    run(60);
    check(int'(level), 0, "R1 idle");

    period = 16'd1;
    for (int s = 0; s < 16; s++) begin
      if (!s[3])     cur_req = "R3 R4 R9";
      else if (s[0]) cur_req = "R3 R7 R9";
      else if (s[1]) cur_req = "R3 R6 R9";
      else           cur_req = "R3 R5 R9";
      write_shape(s[3:0]);
      check(int'(level), s[2] ? 0 : 31, "R8 start");
      run(8 * 32 * 3 + 20);
    end

    cur_req = "R2 ep0";
    period = 16'd0;
    write_shape(4'b1100);
    run(20);
    check(int'(level), 2, "R2 ep0");
    run(300);

    cur_req = "R2 gated";
    period = 16'd3;
    write_shape(4'b1110);
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      tick_en = (i % 3 == 0) || (i % 7 == 2);
    end
    tick_en = 1'b1;

    cur_req = "R8 midramp";
    period = 16'd1;
    write_shape(4'b1100);
    run(100);
    write_shape(4'b1000);
    check(int'(level), 31, "R8 midramp");
    run(100);

    cur_req = "R9 nowrite";
    shape = 4'b0100;
    run(150);
    shape = 4'b1111;
    run(150);

    done = 1'b1;
    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule